// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block converts the digital output of an on-chip voltage comparator into an interrupt request for a CPU. The comparator output is asynchronous to the core clock. It is first synchronised, then compared against its previous sample. The result is classified as a toggle, a falling edge or a rising edge. An event that matches the configured mode sets a sticky flag. The flag raises the interrupt line while both the local enable and the CPU's global interrupt enable are high.

Software sees two byte-wide registers. The control register holds four things: the flag (write one to clear), the local enable, a capture-route bit and a two-bit mode. The route bit forwards the synchronised comparator output to a timer's input-capture trigger. The input-disable register gates the digital read path of the two comparator input pins. The interrupt controller clears the flag by pulsing a vector-acknowledge input when it takes the interrupt. Software should clear the local enable before it rewrites the mode field.

Top module: `cmp_event_irq`

## Requirements
- R1: After reset, both registers read 0x00 and `irq` is low. A comparator input held high through reset and after its release sets no flag.
- R2: With mode 00, either edge of `cmp_in` sets the flag (control bit 7). The flag becomes visible after the third rising clock edge following the input change, and not earlier.
- R3: With mode 10, only a high-to-low transition of `cmp_in` sets the flag.
- R4: With mode 11, only a low-to-high transition of `cmp_in` sets the flag.
- R5: With mode 01 (reserved), no transition of `cmp_in` sets the flag.
- R6: A control write with bit 7 set clears the flag. A control write with bit 7 clear leaves the flag unchanged. Bits 6, 5 and 1:0 of every control write are loaded.
- R7: A one-cycle pulse on `vec_ack` clears the flag.
- R8: If a matching event occurs in the same cycle as a write-one clear and a `vec_ack`, the flag ends up set.
- R9: `irq` is high exactly when the flag, the local enable (control bit 6) and `gie` are all high.
- R10: While control bit 5 is set, `cap_trig` follows the synchronised comparator value. This value lags `cmp_in` by two clock edges. While bit 5 is clear, `cap_trig` is low.
- R11: While bit n of the input-disable register is set, `pin_rd[n]` reads 0. While bit n is clear, `pin_rd[n]` equals `pin_raw[n]`.
- R12: Input-disable register bits 7:2 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator output |
| gie | input | 1 | Global interrupt enable from the CPU |
| vec_ack | input | 1 | Interrupt vector acknowledge, clears the flag |
| reg_wr_ctl | input | 1 | Write strobe for the control register |
| reg_wr_dis | input | 1 | Write strobe for the input-disable register |
| reg_wdata | input | 8 | Write data for both registers |
| ctl_rdata | output | 8 | Control register read value |
| dis_rdata | output | 8 | Input-disable register read value |
| pin_raw | input | 2 | Digital levels of the two comparator input pins |
| pin_rd | output | 2 | Pin read values after input-disable gating |
| cap_trig | output | 1 | Comparator signal routed to timer input capture |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, byte-wide registers and two pins. With these values the three-edge latency from input change to flag is fixed and known. The bench uses that latency to land an event in exactly the same cycle as a write-one clear and an acknowledge. Holding the comparator high through reset exercises the priming window, which is sized from the synchroniser depth.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_NONE   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } ev_mode_e;

    localparam int CTL_FLAG_BIT  = 7;
    localparam int CTL_EN_BIT    = 6;
    localparam int CTL_ROUTE_BIT = 5;

    typedef struct packed {
        logic     en;
        logic     route;
        ev_mode_e mode;
    } ctl_t;

    function automatic logic ev_match(ev_mode_e m, logic cur, logic prv);
        logic r;
        case (m)
            MODE_TOGGLE: r = cur ^ prv;
            MODE_FALL:   r = prv & ~cur;
            MODE_RISE:   r = cur & ~prv;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/cmpirq_edge.sv
module cmpirq_edge
    import cmpirq_pkg::*;
#(
    parameter int PRIME = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cur,
    input  ev_mode_e mode,
    output logic     hit
);
    localparam int CW = $clog2(PRIME + 1);

    logic          prv;
    logic [CW-1:0] cnt;
    logic          ready;

    assign ready = (cnt == CW'(PRIME));

    always_ff @(posedge clk) begin
        if (rst) begin
            prv <= 1'b0;
            cnt <= '0;
        end else begin
            prv <= cur;
            if (!ready) cnt <= cnt + 1'b1;
        end
    end

    assign hit = ready & ev_match(mode, cur, prv);
endmodule

// File: rtl/cmpirq_flag.sv
module cmpirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_event_irq.sv
module cmp_event_irq
    import cmpirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8,
    parameter int NUM_PINS    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_in,
    input  logic                gie,
    input  logic                vec_ack,
    input  logic                reg_wr_ctl,
    input  logic                reg_wr_dis,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    ctl_rdata,
    output logic [REG_W-1:0]    dis_rdata,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_rd,
    output logic                cap_trig,
    output logic                irq
);
    localparam int PRIME = SYNC_STAGES + 1;

    ctl_t                ctl;
    logic [NUM_PINS-1:0] dis;
    logic                cmp_s;
    logic                ev_hit;
    logic                flag;
    logic                w1c;

    cmpirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s)
    );

    cmpirq_edge #(.PRIME(PRIME)) u_edge (
        .clk(clk), .rst(rst), .cur(cmp_s), .mode(ctl.mode), .hit(ev_hit)
    );

    assign w1c = reg_wr_ctl & reg_wdata[CTL_FLAG_BIT];

    cmpirq_flag u_flag (
        .clk(clk), .rst(rst), .set(ev_hit), .clr(w1c | vec_ack), .flag(flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '{en: 1'b0, route: 1'b0, mode: MODE_TOGGLE};
            dis <= '0;
        end else begin
            if (reg_wr_ctl) begin
                ctl.en    <= reg_wdata[CTL_EN_BIT];
                ctl.route <= reg_wdata[CTL_ROUTE_BIT];
                ctl.mode  <= ev_mode_e'(reg_wdata[1:0]);
            end
            if (reg_wr_dis) dis <= reg_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[CTL_FLAG_BIT]  = flag;
        ctl_rdata[CTL_EN_BIT]    = ctl.en;
        ctl_rdata[CTL_ROUTE_BIT] = ctl.route;
        ctl_rdata[1:0]           = ctl.mode;
    end

    assign dis_rdata = {{(REG_W-NUM_PINS){1'b0}}, dis};
    assign pin_rd    = pin_raw & ~dis;
    assign cap_trig  = ctl.route & cmp_s;
    assign irq       = flag & ctl.en & gie;
endmodule

// File: rtl/cmpirq_checker.sv
module cmpirq_checker (
    input logic       clk,
    input logic       rst,
    input logic       gie,
    input logic       vec_ack,
    input logic       reg_wr_ctl,
    input logic       ev_hit,
    input logic [7:0] ctl_rdata,
    input logic [7:0] dis_rdata,
    input logic [1:0] pin_rd,
    input logic       cap_trig,
    input logic       irq
);
    // R9
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gie && ctl_rdata[6] && ctl_rdata[7]));

    // R5
    p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[1:0] == 2'b01 && !ctl_rdata[7] && !reg_wr_ctl) |=> !ctl_rdata[7]);

    // R7
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !ev_hit) |=> !ctl_rdata[7]);

    // R8
    p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ev_hit |=> ctl_rdata[7]);

    // R10
    p_route_off_r10: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[5] |-> !cap_trig);

    // R12
    p_dis_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
        dis_rdata[7:2] == 6'd0);

    // R11
    p_pin_gate_r11: assert property (@(posedge clk) disable iff (rst)
        dis_rdata[0] |-> !pin_rd[0]);
endmodule

bind cmp_event_irq cmpirq_checker u_chk (
    .clk(clk), .rst(rst), .gie(gie), .vec_ack(vec_ack),
    .reg_wr_ctl(reg_wr_ctl), .ev_hit(ev_hit),
    .ctl_rdata(ctl_rdata), .dis_rdata(dis_rdata), .pin_rd(pin_rd),
    .cap_trig(cap_trig), .irq(irq)
);

// File: tb/sim_cmp_event_irq.sv
module sim_cmp_event_irq;
    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_in = 1'b1;
    logic       gie = 1'b0;
    logic       vec_ack = 1'b0;
    logic       reg_wr_ctl = 1'b0;
    logic       reg_wr_dis = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic [7:0] dis_rdata;
    logic [1:0] pin_raw = 2'b00;
    logic [1:0] pin_rd;
    logic       cap_trig;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(TCLK/2) clk = ~clk;

    cmp_event_irq u0 (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .gie(gie), .vec_ack(vec_ack),
        .reg_wr_ctl(reg_wr_ctl), .reg_wr_dis(reg_wr_dis), .reg_wdata(reg_wdata),
        .ctl_rdata(ctl_rdata), .dis_rdata(dis_rdata), .pin_raw(pin_raw),
        .pin_rd(pin_rd), .cap_trig(cap_trig), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        reg_wdata = d; reg_wr_ctl = 1'b1;
        step(1);
        reg_wr_ctl = 1'b0;
    endtask

    task automatic wr_dis(input logic [7:0] d);
        reg_wdata = d; reg_wr_dis = 1'b1;
        step(1);
        reg_wr_dis = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic t_reset;
        check("R1 ctl after reset", ctl_rdata, 8'h00);
        check("R1 dis after reset", dis_rdata, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        step(6);
        check("R1 no false edge", ctl_rdata, 8'h00);
    endtask

    task automatic t_toggle;
        wr_ctl(8'h00);
        cmp_in = 1'b0;
        step(2);
        check("R2 not before third edge", ctl_rdata, 8'h00);
        step(1);
        check("R2 falling sets flag", ctl_rdata, 8'h80);
        wr_ctl(8'h80);
        cmp_in = 1'b1;
        step(3);
        check("R2 rising sets flag", ctl_rdata, 8'h80);
        wr_ctl(8'h80);
    endtask

    task automatic t_fall;
        wr_ctl(8'h02);
        cmp_in = 1'b0; step(4); wr_ctl(8'h82);
        cmp_in = 1'b1; step(4);
        check("R3 rise ignored", ctl_rdata, 8'h02);
        cmp_in = 1'b0; step(3);
        check("R3 fall sets", ctl_rdata, 8'h82);
        wr_ctl(8'h82);
    endtask

    task automatic t_rise;
        wr_ctl(8'h03);
        cmp_in = 1'b1; step(3);
        check("R4 rise sets", ctl_rdata, 8'h83);
        wr_ctl(8'h83);
        cmp_in = 1'b0; step(4);
        check("R4 fall ignored", ctl_rdata, 8'h03);
    endtask

    task automatic t_reserved;
        wr_ctl(8'h01);
        cmp_in = 1'b1; step(4);
        check("R5 rise no event", ctl_rdata, 8'h01);
        cmp_in = 1'b0; step(4);
        check("R5 fall no event", ctl_rdata, 8'h01);
    endtask

    task automatic t_w1c;
        wr_ctl(8'h00);
        cmp_in = 1'b1; step(3);
        check("R6 flag set", ctl_rdata, 8'h80);
        wr_ctl(8'h00);
        check("R6 write zero keeps flag", ctl_rdata, 8'h80);
        wr_ctl(8'h80);
        check("R6 write one clears", ctl_rdata, 8'h00);
    endtask

    task automatic t_ack;
        cmp_in = 1'b0; step(3);
        check("R7 flag set", ctl_rdata, 8'h80);
        vec_ack = 1'b1; step(1); vec_ack = 1'b0;
        check("R7 ack clears", ctl_rdata, 8'h00);
    endtask

    task automatic t_race;
        cmp_in = 1'b1; step(2);
        reg_wdata = 8'h80; reg_wr_ctl = 1'b1; vec_ack = 1'b1;
        step(1);
        reg_wr_ctl = 1'b0; vec_ack = 1'b0;
        check("R8 event beats clear", ctl_rdata, 8'h80);
        wr_ctl(8'h80);
    endtask

    task automatic t_irq;
        cmp_in = 1'b0; step(3);
        check("R9 flag only", {7'd0, irq}, 8'h00);
        wr_ctl(8'h40);
        check("R9 no gie", {7'd0, irq}, 8'h00);
        gie = 1'b1; #1;
        check("R9 all set", {7'd0, irq}, 8'h01);
        wr_ctl(8'h00);
        check("R9 enable off", {7'd0, irq}, 8'h00);
        wr_ctl(8'h40);
        check("R9 enable back", {7'd0, irq}, 8'h01);
        vec_ack = 1'b1; step(1); vec_ack = 1'b0;
        check("R9 flag cleared", {7'd0, irq}, 8'h00);
        gie = 1'b0;
        wr_ctl(8'h00);
    endtask

    task automatic t_route;
        wr_ctl(8'h20);
        check("R10 route on, input low", {7'd0, cap_trig}, 8'h00);
        cmp_in = 1'b1; step(1);
        check("R10 one edge lag", {7'd0, cap_trig}, 8'h00);
        step(1);
        check("R10 follows input", {7'd0, cap_trig}, 8'h01);
        wr_ctl(8'h80);
        check("R10 route off", {7'd0, cap_trig}, 8'h00);
    endtask

    task automatic t_pins;
        pin_raw = 2'b11; #1;
        check("R11 no disable", {6'd0, pin_rd}, 8'h03);
        wr_dis(8'h01);
        check("R11 pin0 disabled", {6'd0, pin_rd}, 8'h02);
        wr_dis(8'hFF);
        check("R12 upper bits zero", dis_rdata, 8'h03);
        check("R11 both disabled", {6'd0, pin_rd}, 8'h00);
        wr_dis(8'h00);
        check("R11 released", {6'd0, pin_rd}, 8'h03);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_toggle();
        t_fall();
        t_rise();
        t_reserved();
        t_w1c();
        t_ack();
        t_race();
        t_irq();
        t_route();
        t_pins();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule